// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block sits at the front of a small 32-bit processor whose instructions are 1 to 7 bytes long. It keeps the program counter. It asks memory for a window of bytes that starts at that address. From the leading byte, and in a few four-byte cases also from the second byte, it works out the instruction length and a packing rule. It then hands the downstream stage a fixed-format 32-bit instruction word and a 24-bit extension word.

Multi-byte immediates in the instruction stream are little-endian. The aligner moves them into fixed positions, so that later opcode matching sees every form in one layout. When the downstream stage accepts a decoded instruction, the program counter moves forward by the instruction length. A leading byte that has no assigned meaning is passed on with an illegal flag and a length of zero, so the counter does not move.

The window side uses a request/valid pair and the decode side uses a valid/ready pair. The aligner holds one decoded instruction at a time.

Top module: `vlen_fetch_aligner`

## Requirements
- R1: After reset `dec_valid` is 0, `fetch_req` is 1 and `fetch_pc` equals the parameter `RESET_PC`.
- R2: These leading bytes are one-byte forms: 0x00, 0x04, 0x08, 0x0C, 0x10–0x1F, 0x3C–0x3F, 0x40, 0x41, 0x44, 0x45, 0x48, 0x49, 0x4C, 0x4D, 0x50–0x57, 0x60–0x7F, 0xCB, 0xD0–0xDB, 0xE0–0xEF, 0xFF, and every byte in 0x80–0xBF whose bits [3:2] differ from bits [1:0]. For these, `dec_word` is the byte zero-extended, `dec_ext` is 0 and `dec_len` is 1.
- R3: These leading bytes are two-byte forms with `dec_word` = {16'h0, b0, b1}: bytes in 0x80–0xBF whose bits [3:2] equal bits [1:0], and also 0x20–0x23, 0x28–0x2B, 0x42, 0x43, 0x46, 0x47, 0x4A, 0x4B, 0x4E, 0x4F, 0x58–0x5F, 0xC0–0xCA, 0xCE, 0xCF and 0xF0–0xF6.
- R4: Leading bytes 0x01–0x03, 0x05–0x07, 0x09–0x0B, 0x0D–0x0F, 0x24–0x27, 0x2C–0x2F, 0x30–0x3B and 0xCC have length 3, with `dec_word` = {8'h0, b0, b2, b1}.
- R5: Leading bytes 0xDE, 0xDF, 0xF8 and 0xF9 have length 3, with `dec_word` = {8'h0, b0, b1, b2}.
- R6: Leading bytes 0xFA and 0xFB have length 4 and `dec_ext` = 0. If b0 = 0xFA and b1 is in 0xF0–0xFB, then `dec_word` = {b0, b1, b2, b3}. Otherwise `dec_word` = {b0, b1, b3, b2}.
- R7: 0xCD has length 5, with word {b0, b2, b1, b3} and extension {16'h0, b4}. 0xDC has length 5, with word {b0, b4, b3, b2} and extension {16'h0, b1}.
- R8: 0xFC and 0xFD have length 6, with word {b0, b1, b5, b4} and extension {8'h0, b3, b2}.
- R9: 0xDD has length 7, with word {b0, b4, b3, b2} and extension {b1, b5, b6}. 0xFE has length 7, with word {b0, b1, b5, b4} and extension {b3, b2, b6}.
- R10: Any other leading byte (0xF7) sets `dec_illegal`, with `dec_len`, `dec_word` and `dec_ext` all 0. Acceptance leaves `fetch_pc` unchanged.
- R11: `dec_pc` is the address of the instruction on display. When `dec_valid` and `dec_ready` are both high at a clock edge, `fetch_pc` becomes the old value plus `dec_len` after that edge.
- R12: While `dec_valid` is high and `dec_ready` is low, all decode outputs hold and `fetch_req` stays low. Any window that is presented during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Aligner is ready to take a window at `fetch_pc` |
| fetch_pc | output | PC_W | Address of the next window |
| win_valid | input | 1 | Window bytes are valid |
| win_data | input | 8*WIN_BYTES | Window bytes, byte 0 in bits [7:0] |
| dec_valid | output | 1 | A decoded instruction is on display |
| dec_ready | input | 1 | Downstream accepts the instruction |
| dec_pc | output | PC_W | Address of the displayed instruction |
| dec_word | output | 32 | Repacked instruction word |
| dec_ext | output | 24 | Repacked extension word |
| dec_len | output | LEN_W | Instruction length in bytes, 0 when illegal |
| dec_illegal | output | 1 | Leading byte is unassigned |

## Verification
The two functions that can fall in the same cycle are the acceptance of a displayed instruction, which advances the counter, and a new window arriving while the previous decode is still held. The bench provokes this by holding `dec_ready` low for several cycles while it keeps `win_valid` high with changing bytes. It judges that the word, extension and length do not move and that `fetch_req` stays low. It then releases `dec_ready` and checks that the counter moved by exactly the held length and not by anything taken from the ignored windows.

// File: rtl/vlen_fa_pkg.sv
package vlen_fa_pkg;

   localparam int WORD_W = 32;
   localparam int EXT_W  = 24;
   localparam int MAX_LEN = 7;

   typedef enum logic [3:0] {
      CLS_ILL  = 4'd0,
      CLS_B1   = 4'd1,
      CLS_B2   = 4'd2,
      CLS_B3LE = 4'd3,
      CLS_B3BE = 4'd4,
      CLS_B4BE = 4'd5,
      CLS_B4MX = 4'd6,
      CLS_B5CD = 4'd7,
      CLS_B5DC = 4'd8,
      CLS_B6   = 4'd9,
      CLS_B7DD = 4'd10,
      CLS_B7FE = 4'd11
   } insn_cls_e;

   function automatic logic [2:0] cls_len(input insn_cls_e c);
      case (c)
         CLS_B1:                  cls_len = 3'd1;
         CLS_B2:                  cls_len = 3'd2;
         CLS_B3LE, CLS_B3BE:      cls_len = 3'd3;
         CLS_B4BE, CLS_B4MX:      cls_len = 3'd4;
         CLS_B5CD, CLS_B5DC:      cls_len = 3'd5;
         CLS_B6:                  cls_len = 3'd6;
         CLS_B7DD, CLS_B7FE:      cls_len = 3'd7;
         default:                 cls_len = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/vlen_fa_classify.sv
module vlen_fa_classify
   import vlen_fa_pkg::*;
(
   input  logic [7:0] lead_b,
   input  logic [7:0] next_b,
   output insn_cls_e  cls
);

   always_comb begin
      cls = CLS_ILL;
      case (lead_b) inside
         8'h00, 8'h04, 8'h08, 8'h0C, [8'h10:8'h1F], [8'h3C:8'h3F],
         8'h40, 8'h41, 8'h44, 8'h45, 8'h48, 8'h49, 8'h4C, 8'h4D,
         [8'h50:8'h57], [8'h60:8'h7F], 8'hCB, [8'hD0:8'hDB],
         [8'hE0:8'hEF], 8'hFF:
            cls = CLS_B1;
         [8'h80:8'hBF]:
            cls = (lead_b[3:2] == lead_b[1:0]) ? CLS_B2 : CLS_B1;
         [8'h20:8'h23], [8'h28:8'h2B], 8'h42, 8'h43, 8'h46, 8'h47,
         8'h4A, 8'h4B, 8'h4E, 8'h4F, [8'h58:8'h5F], [8'hC0:8'hCA],
         8'hCE, 8'hCF, [8'hF0:8'hF6]:
            cls = CLS_B2;
         [8'h01:8'h03], [8'h05:8'h07], [8'h09:8'h0B], [8'h0D:8'h0F],
         [8'h24:8'h27], [8'h2C:8'h2F], [8'h30:8'h3B], 8'hCC:
            cls = CLS_B3LE;
         8'hDE, 8'hDF, 8'hF8, 8'hF9:
            cls = CLS_B3BE;
         8'hFA, 8'hFB:
            cls = (lead_b == 8'hFA && next_b[7:4] == 4'hF && next_b[3:2] != 2'b11)
                  ? CLS_B4BE : CLS_B4MX;
         8'hCD:         cls = CLS_B5CD;
         8'hDC:         cls = CLS_B5DC;
         8'hFC, 8'hFD:  cls = CLS_B6;
         8'hDD:         cls = CLS_B7DD;
         8'hFE:         cls = CLS_B7FE;
         default:       cls = CLS_ILL;
      endcase
   end

endmodule

// File: rtl/vlen_fa_pack.sv
module vlen_fa_pack
   import vlen_fa_pkg::*;
(
   input  insn_cls_e           cls,
   input  logic [6:0][7:0]     b,
   output logic [WORD_W-1:0]   word,
   output logic [EXT_W-1:0]    ext
);

   always_comb begin
      word = '0;
      ext  = '0;
      case (cls)
         CLS_B1:   word = {24'h0, b[0]};
         CLS_B2:   word = {16'h0, b[0], b[1]};
         CLS_B3LE: word = {8'h0, b[0], b[2], b[1]};
         CLS_B3BE: word = {8'h0, b[0], b[1], b[2]};
         CLS_B4BE: word = {b[0], b[1], b[2], b[3]};
         CLS_B4MX: word = {b[0], b[1], b[3], b[2]};
         CLS_B5CD: begin
            word = {b[0], b[2], b[1], b[3]};
            ext  = {16'h0, b[4]};
         end
         CLS_B5DC: begin
            word = {b[0], b[4], b[3], b[2]};
            ext  = {16'h0, b[1]};
         end
         CLS_B6: begin
            word = {b[0], b[1], b[5], b[4]};
            ext  = {8'h0, b[3], b[2]};
         end
         CLS_B7DD: begin
            word = {b[0], b[4], b[3], b[2]};
            ext  = {b[1], b[5], b[6]};
         end
         CLS_B7FE: begin
            word = {b[0], b[1], b[5], b[4]};
            ext  = {b[3], b[2], b[6]};
         end
         default: begin
            word = '0;
            ext  = '0;
         end
      endcase
   end

endmodule

// File: rtl/vlen_fetch_aligner.sv
module vlen_fetch_aligner
   import vlen_fa_pkg::*;
#(
   parameter int          PC_W      = 32,
   parameter int          WIN_BYTES = 7,
   parameter logic [31:0] RESET_PC  = 32'h0000_1000,
   localparam int         WIN_W     = 8 * WIN_BYTES,
   localparam int         LEN_W     = $clog2(WIN_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              fetch_req,
   output logic [PC_W-1:0]   fetch_pc,
   input  logic              win_valid,
   input  logic [WIN_W-1:0]  win_data,
   output logic              dec_valid,
   input  logic              dec_ready,
   output logic [PC_W-1:0]   dec_pc,
   output logic [WORD_W-1:0] dec_word,
   output logic [EXT_W-1:0]  dec_ext,
   output logic [LEN_W-1:0]  dec_len,
   output logic              dec_illegal
);

   generate
      if (WIN_BYTES < MAX_LEN) begin : g_bad_win
         $error("WIN_BYTES must cover the longest instruction");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("PC_W too small");
      end
   endgenerate

   logic [6:0][7:0] win_b;

   generate
      for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_slice
         assign win_b[gi] = win_data[8*gi +: 8];
      end
   endgenerate

   insn_cls_e           cls;
   logic [WORD_W-1:0]   pk_word;
   logic [EXT_W-1:0]    pk_ext;

   vlen_fa_classify u_cls (
      .lead_b (win_b[0]),
      .next_b (win_b[1]),
      .cls    (cls)
   );

   vlen_fa_pack u_pack (
      .cls  (cls),
      .b    (win_b),
      .word (pk_word),
      .ext  (pk_ext)
   );

   logic [PC_W-1:0]   pc_q;
   logic              vld_q;
   logic [WORD_W-1:0] word_q;
   logic [EXT_W-1:0]  ext_q;
   logic [LEN_W-1:0]  len_q;
   logic              ill_q;

   logic take_win;
   logic retire;

   assign take_win = win_valid && !vld_q;
   assign retire   = vld_q && dec_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC[PC_W-1:0];
         vld_q  <= 1'b0;
         word_q <= '0;
         ext_q  <= '0;
         len_q  <= '0;
         ill_q  <= 1'b0;
      end else begin
         if (retire) begin
            pc_q  <= pc_q + PC_W'(len_q);
            vld_q <= 1'b0;
         end else if (take_win) begin
            vld_q  <= 1'b1;
            word_q <= pk_word;
            ext_q  <= pk_ext;
            len_q  <= LEN_W'(cls_len(cls));
            ill_q  <= (cls == CLS_ILL);
         end
      end
   end

   assign fetch_req   = !vld_q;
   assign fetch_pc    = pc_q;
   assign dec_valid   = vld_q;
   assign dec_pc      = pc_q;
   assign dec_word    = word_q;
   assign dec_ext     = ext_q;
   assign dec_len     = len_q;
   assign dec_illegal = ill_q;

endmodule

// File: rtl/vlen_fetch_aligner_chk.sv
module vlen_fetch_aligner_chk #(
   parameter int PC_W  = 32,
   parameter int LEN_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fetch_req,
   input logic [PC_W-1:0]  fetch_pc,
   input logic             dec_valid,
   input logic             dec_ready,
   input logic [31:0]      dec_word,
   input logic [23:0]      dec_ext,
   input logic [LEN_W-1:0] dec_len,
   input logic             dec_illegal
);

   p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_word) && $stable(dec_ext)
                                     && $stable(dec_len) && $stable(dec_illegal)));

   p_stall_no_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_ready) |=> !fetch_req);

   p_pc_adv_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_ready) |=> (fetch_pc == $past(fetch_pc) + PC_W'($past(dec_len))));

   p_pc_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_valid && dec_ready) |=> $stable(fetch_pc));

   p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_illegal) |-> (dec_len == '0 && dec_word == '0));

   p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_illegal) |-> (dec_len != '0 && dec_len <= LEN_W'(7)));

   p_short_no_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_len <= LEN_W'(4)) |-> (dec_ext == '0));

endmodule

bind vlen_fetch_aligner vlen_fetch_aligner_chk #(.PC_W(PC_W), .LEN_W(LEN_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_req   (fetch_req),
   .fetch_pc    (fetch_pc),
   .dec_valid   (dec_valid),
   .dec_ready   (dec_ready),
   .dec_word    (dec_word),
   .dec_ext     (dec_ext),
   .dec_len     (dec_len),
   .dec_illegal (dec_illegal)
);

// File: tb/vlen_fetch_aligner_tb_top.sv
module vlen_fetch_aligner_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] START_PC   = 32'h0000_1000;

   typedef struct packed {
      logic [55:0] data;
      logic [31:0] word;
      logic [23:0] ext;
      logic [2:0]  len;
      logic        ill;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{56'h66554433221100, 32'h00000000, 24'h000000, 3'd1, 1'b0, 4'd2},
      '{56'h66554433221181, 32'h00000081, 24'h000000, 3'd1, 1'b0, 4'd2},
      '{56'h66554433221185, 32'h00008511, 24'h000000, 3'd2, 1'b0, 4'd3},
      '{56'h665544332211F3, 32'h0000F311, 24'h000000, 3'd2, 1'b0, 4'd3},
      '{56'h665544332211CC, 32'h00CC2211, 24'h000000, 3'd3, 1'b0, 4'd4},
      '{56'h66554433221101, 32'h00012211, 24'h000000, 3'd3, 1'b0, 4'd4},
      '{56'h665544332211F8, 32'h00F81122, 24'h000000, 3'd3, 1'b0, 4'd5},
      '{56'h6655443322F4FA, 32'hFAF42233, 24'h000000, 3'd4, 1'b0, 4'd6},
      '{56'h665544332211FA, 32'hFA113322, 24'h000000, 3'd4, 1'b0, 4'd6},
      '{56'h6655443322F0FB, 32'hFBF03322, 24'h000000, 3'd4, 1'b0, 4'd6},
      '{56'h665544332211CD, 32'hCD221133, 24'h000044, 3'd5, 1'b0, 4'd7},
      '{56'h665544332211DC, 32'hDC443322, 24'h000011, 3'd5, 1'b0, 4'd7},
      '{56'h665544332211FC, 32'hFC115544, 24'h003322, 3'd6, 1'b0, 4'd8},
      '{56'h665544332211DD, 32'hDD443322, 24'h115566, 3'd7, 1'b0, 4'd9},
      '{56'h665544332211FE, 32'hFE115544, 24'h332266, 3'd7, 1'b0, 4'd9},
      '{56'h665544332211F7, 32'h00000000, 24'h000000, 3'd0, 1'b1, 4'd10},
      '{56'h665544332211FF, 32'h000000FF, 24'h000000, 3'd1, 1'b0, 4'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req;
   logic [31:0] fetch_pc;
   logic        win_valid = 1'b0;
   logic [55:0] win_data = '0;
   logic        dec_valid;
   logic        dec_ready = 1'b0;
   logic [31:0] dec_pc;
   logic [31:0] dec_word;
   logic [23:0] dec_ext;
   logic [2:0]  dec_len;
   logic        dec_illegal;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vlen_fetch_aligner #(.PC_W(32), .WIN_BYTES(7), .RESET_PC(START_PC)) dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
      .win_valid(win_valid), .win_data(win_data), .dec_valid(dec_valid),
      .dec_ready(dec_ready), .dec_pc(dec_pc), .dec_word(dec_word), .dec_ext(dec_ext),
      .dec_len(dec_len), .dec_illegal(dec_illegal)
   );

   function automatic string req_name(input logic [3:0] r);
      case (r)
         4'd2:  req_name = "R2";
         4'd3:  req_name = "R3";
         4'd4:  req_name = "R4";
         4'd5:  req_name = "R5";
         4'd6:  req_name = "R6";
         4'd7:  req_name = "R7";
         4'd8:  req_name = "R8";
         4'd9:  req_name = "R9";
         4'd10: req_name = "R10";
         default: req_name = "R?";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] exp_pc;
      logic [31:0] held_word;
      exp_pc = START_PC;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "dec_valid", 64'(dec_valid), 64'd0);
      chk("R1", "fetch_req", 64'(fetch_req), 64'd1);
      chk("R1", "fetch_pc",  64'(fetch_pc), 64'(START_PC));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "fetch_pc after release", 64'(fetch_pc), 64'(START_PC));

      for (int i = 0; i < NV; i++) begin
         win_valid = 1'b1;
         win_data  = VECS[i].data;
         @(negedge clk);
         win_valid = 1'b0;
         chk(req_name(VECS[i].req), "dec_valid", 64'(dec_valid), 64'd1);
         chk(req_name(VECS[i].req), "dec_word", 64'(dec_word), 64'(VECS[i].word));
         chk(req_name(VECS[i].req), "dec_ext", 64'(dec_ext), 64'(VECS[i].ext));
         chk(req_name(VECS[i].req), "dec_len", 64'(dec_len), 64'(VECS[i].len));
         chk(req_name(VECS[i].req), "dec_illegal", 64'(dec_illegal), 64'(VECS[i].ill));
         // R11: displayed address
         chk("R11", "dec_pc", 64'(dec_pc), 64'(exp_pc));
         dec_ready = 1'b1;
         @(negedge clk);
         dec_ready = 1'b0;
         exp_pc = exp_pc + 32'(VECS[i].len);
         // R11 advance, R10 no advance on illegal
         chk(VECS[i].ill ? "R10" : "R11", "fetch_pc after accept", 64'(fetch_pc), 64'(exp_pc));
         chk("R11", "fetch_req after accept", 64'(fetch_req), 64'd1);
      end

      // R12: stall with competing windows
      win_valid = 1'b1;
      win_data  = 56'h665544332211FD;
      @(negedge clk);
      held_word = dec_word;
      chk("R8", "dec_word FD", 64'(dec_word), 64'h00000000FD115544);
      for (int k = 0; k < 4; k++) begin
         win_data = {48'h0, 8'h85 + 8'(k)} | 56'h77000000000000;
         @(negedge clk);
         chk("R12", "word held", 64'(dec_word), 64'(held_word));
         chk("R12", "len held", 64'(dec_len), 64'd6);
         chk("R12", "fetch_req low", 64'(fetch_req), 64'd0);
      end
      win_valid = 1'b0;
      dec_ready = 1'b1;
      @(negedge clk);
      dec_ready = 1'b0;
      exp_pc = exp_pc + 32'd6;
      chk("R12", "pc after stall release", 64'(fetch_pc), 64'(exp_pc));
      chk("R12", "no stray decode", 64'(dec_valid), 64'd0);

      // R1: reset mid-stream
      win_valid = 1'b1;
      win_data  = 56'h665544332211DD;
      @(negedge clk);
      win_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "dec_valid in reset", 64'(dec_valid), 64'd0);
      chk("R1", "fetch_pc in reset", 64'(fetch_pc), 64'(START_PC));
      finish_run();
   end

endmodule